// File: doc/BRIEF.md
# Buffered 16-bit Timer/Counter

This block is a 16-bit up-counter that an 8-bit register bus reaches as two bytes. It can count pulses of an internal instruction tick or rising edges of an external oscillator input. Either source passes through a prescaler that divides by 1, 2, 4 or 8. The external input is brought into the system clock domain by a short flop chain and an edge detector. The synchronize control bit picks either the two-stage path or a faster single-stage path.

In 16-bit mode, software never touches the live high byte. A read of the low byte copies the live high byte into a shadow buffer, so the next read of the high address returns a value that matches the low byte already read, even if the count has since carried. A write to the high address fills only the shadow buffer. A later low-byte write commits both bytes in the same cycle. When the count wraps from all ones to zero, a sticky flag is set, and that flag ANDed with an enable drives the interrupt. An external compare-match pulse resets the count to zero, but a bus write to the count in the same cycle takes precedence over it.

The bus is a plain register port: read data is combinational on the address, writes and read side effects take place on the clock edge, and there is no back-pressure. Addresses: 0 = count low byte, 1 = high byte (buffer or live), 2 = control, 3 = flag.

Top module: `tmr16_buf`

## Requirements
- R1: After reset, all four addresses read 0x00 and `irq` is low.
- R2: The control byte at address 2 has these fields: bit 0 run, bit 1 source (1 = external), bit 2 synchronize, bits 5:4 prescale, bit 6 interrupt enable, bit 7 16-bit mode. While run is set, the count advances by one on every 2^prescale-th pulse of the selected source.
- R3: In 16-bit mode, a read of address 0 loads the live high byte into the buffer in that cycle, and address 1 then reads the buffer.
- R4: In 16-bit mode, a write to address 1 changes only the buffer. A write to address 0 loads the low byte and moves the buffer into the high byte on the same edge.
- R5: A write to address 0 clears the prescaler. A write to address 1 leaves the prescaler unchanged.
- R6: An increment from 0xFFFF gives 0x0000 and sets the flag (address 3 bit 0). `irq` equals flag AND interrupt enable.
- R7: A high `evt_trig` resets the count to 0x0000 on the next edge and never sets the flag.
- R8: A bus write to the count in the same cycle as `evt_trig` wins, and the reset is dropped.
- R9: With the external source selected, a rising edge of `ext_clk` advances the count (at prescale 1) on the second edge after it is sampled if synchronize is clear, and on the third if it is set.
- R10: With 16-bit mode clear, address 1 reads and writes the live high byte directly.
- R11: Writing 0 to address 3 bit 0 clears the flag, and writing 1 there has no effect. A wrap in the same cycle as the clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (its side effect is the buffer load) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| inst_tick | input | 1 | Internal instruction tick, one cycle per pulse |
| ext_clk | input | 1 | External or oscillator count input |
| evt_trig | input | 1 | Special event reset pulse |
| irq | output | 1 | Overflow interrupt request |

## Verification
Read data is due in the same cycle as the address, so the bench checks it after the inputs settle and before the edge. Register effects (count, buffer, flag, prescaler) take effect on the edge that samples the strobe. `irq` follows one edge after the wrap and is checked at the following falling edge. External edges take two or three edges depending on the synchronize bit, and the bench peeks at the count in each intermediate cycle to confirm that it changes on the expected edge and no earlier.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam logic [1:0] A_LO   = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_CTL  = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  typedef struct packed {
    logic       mode16;
    logic       irq_en;
    logic [1:0] presc;
    logic       spare;
    logic       sync_en;
    logic       src_ext;
    logic       run;
  } ctl_t;
endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic sync_en,
  output logic rise
);
  localparam int LEN = STAGES + 1;
  logic [LEN-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LEN-2:0], sig_in};
  end

  always_comb begin
    if (sync_en) rise = chain[STAGES-1] & ~chain[STAGES];
    else         rise = chain[0] & ~chain[1];
  end

  // R9: an edge gives a single-cycle pulse
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            clr,
  input  logic [PS_W-1:0] sel,
  output logic            out_tick
);
  localparam int DIV_W = (1 << PS_W) - 1;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = DIV_W'((1 << sel) - 1);
    out_tick = en && ((cnt & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end

  // R5: a low-byte write empties the prescaler
  assert_presc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/tmr16_buf.sv
module tmr16_buf
  import tmr16_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int PS_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             inst_tick,
  input  logic             ext_clk,
  input  logic             evt_trig,
  output logic             irq
);
  localparam int CNT_W = 2 * BUS_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ctl_t             ctl;
  logic [CNT_W-1:0] count;
  logic [BUS_W-1:0] hbuf;
  logic             ovf;
  logic             ext_rise, src_pulse, inc;
  logic             lo_wr, hi_wr, live_hi_wr, cnt_wr, lo_rd, ovf_set, flag_clr;

  always_comb begin
    lo_wr      = bus_wr && (bus_addr == A_LO);
    hi_wr      = bus_wr && (bus_addr == A_HI);
    live_hi_wr = hi_wr && !ctl.mode16;
    cnt_wr     = lo_wr || live_hi_wr;
    lo_rd      = bus_rd && (bus_addr == A_LO);
    src_pulse  = ctl.run && (ctl.src_ext ? ext_rise : inst_tick);
    ovf_set    = inc && !cnt_wr && !evt_trig && (count == CNT_MAX);
    flag_clr   = bus_wr && (bus_addr == A_FLAG) && !bus_wdata[0];
  end

  tmr16_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(ext_clk), .sync_en(ctl.sync_en), .rise(ext_rise)
  );

  tmr16_presc #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .en(src_pulse), .clr(lo_wr), .sel(ctl.presc), .out_tick(inc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (cnt_wr) begin
      if (lo_wr) count[BUS_W-1:0] <= bus_wdata;
      if (live_hi_wr)              count[CNT_W-1:BUS_W] <= bus_wdata;
      else if (lo_wr && ctl.mode16) count[CNT_W-1:BUS_W] <= hbuf;
    end else if (evt_trig) begin
      count <= '0;
    end else if (inc) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hbuf <= '0;
    else if (hi_wr && ctl.mode16)   hbuf <= bus_wdata;
    else if (lo_rd && ctl.mode16)   hbuf <= count[CNT_W-1:BUS_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf <= 1'b0;
    else if (ovf_set)  ovf <= 1'b1;
    else if (flag_clr) ovf <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ctl <= '0;
    else if (bus_wr && (bus_addr == A_CTL))    ctl <= ctl_t'(bus_wdata);
  end

  always_comb begin
    unique case (bus_addr)
      A_LO:    bus_rdata = count[BUS_W-1:0];
      A_HI:    bus_rdata = ctl.mode16 ? hbuf : count[CNT_W-1:BUS_W];
      A_CTL:   bus_rdata = ctl;
      default: bus_rdata = {{(BUS_W-1){1'b0}}, ovf};
    endcase
    irq = ovf && ctl.irq_en;
  end

  // R7: trigger without a competing write zeroes the count
  assert_trig_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_trig && !cnt_wr) |=> (count == '0));
  // R7: trigger never raises the flag
  assert_trig_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && evt_trig) |=> !ovf);
  // R6: wrap sets the flag
  assert_wrap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> (ovf && (count == '0)));
  // R4: buffered high write leaves the count alone
  assert_hi_buffer_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && ctl.mode16 && !evt_trig && !inc) |=> $stable(count));
  // R8: write beats trigger
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && evt_trig) |=> (count[BUS_W-1:0] == $past(bus_wdata)));
endmodule

// File: tb/tb_tmr16_buf.sv
`timescale 1ns/1ps
module tb_tmr16_buf;
  logic       clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic       bus_wr = 0, bus_rd = 0, inst_tick = 0, ext_clk = 0, evt_trig = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       irq;
  int errors = 0, checks = 0;

  // bench model
  logic [15:0] m_cnt = 0;
  logic [2:0]  m_pre = 0;
  logic [7:0]  m_ctl = 0, m_buf = 0;
  logic        m_ovf = 0;

  always #2 clk = ~clk;

  tmr16_buf dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .inst_tick(inst_tick),
    .ext_clk(ext_clk), .evt_trig(evt_trig), .irq(irq));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt[7:0];
      2'd1: return m_ctl[7] ? m_buf : m_cnt[15:8];
      2'd2: return m_ctl;
      default: return {7'b0, m_ovf};
    endcase
  endfunction

  // one bus cycle; call at a falling edge
  task automatic cyc(input logic w, input logic r, input logic [1:0] a, input logic [7:0] d,
                     input logic tk, input logic tg, input string tag);
    logic lo_w, hi_w, live_w, inc, pen, set;
    logic [2:0] mask;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; inst_tick = tk; evt_trig = tg;
    #1;
    if (r) check(tag, {8'h0, bus_rdata}, {8'h0, m_read(a)});
    @(posedge clk);
    lo_w = w && a == 0; hi_w = w && a == 1; live_w = hi_w && !m_ctl[7];
    pen = m_ctl[0] && !m_ctl[1] && tk;
    mask = 3'((1 << m_ctl[5:4]) - 1);
    inc = pen && ((m_pre & mask) == mask);
    set = inc && !(lo_w || live_w) && !tg && m_cnt == 16'hFFFF;
    if (lo_w) m_pre = 0; else if (pen) m_pre = m_pre + 1;
    if (hi_w && m_ctl[7]) begin end
    if (lo_w || live_w) begin
      if (lo_w) m_cnt[7:0] = d;
      if (live_w) m_cnt[15:8] = d; else if (lo_w && m_ctl[7]) m_cnt[15:8] = m_buf;
    end else if (tg) m_cnt = 0;
    else if (inc) m_cnt = m_cnt + 1;
    if (hi_w && m_ctl[7]) m_buf = d;
    else if (r && a == 0 && m_ctl[7]) m_buf = m_cnt_prev_hi;
    if (set) m_ovf = 1; else if (w && a == 3 && !d[0]) m_ovf = 0;
    if (w && a == 2) m_ctl = d;
    @(negedge clk);
    check("R6 irq", {15'h0, irq}, {15'h0, m_ovf & m_ctl[6]});
  endtask

  logic [7:0] m_cnt_prev_hi;
  always @(posedge clk) m_cnt_prev_hi = dut.bus_addr == 2'd0 ? m_cnt[15:8] : m_cnt[15:8];

  task automatic idle(input int n, input logic tk);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, tk, 0, "idle");
  endtask

  task automatic peek_lo(input string tag, input logic [7:0] exp);
    bus_addr = 0; bus_wr = 0; bus_rd = 0; #1;
    check(tag, {8'h0, bus_rdata}, {8'h0, exp});
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5E));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) cyc(0, 1, 2'(a), 0, 0, 0, "R1");
    // R2 counting at divide by 4
    cyc(1, 0, 2, 8'h21, 0, 0, "R2");
    idle(9, 1);
    cyc(0, 1, 0, 0, 0, 0, "R2");
    // R5 high write keeps prescaler, low write clears it (16-bit mode)
    cyc(1, 0, 2, 8'hB1, 0, 0, "R5");
    cyc(1, 0, 0, 8'h10, 0, 0, "R5");
    idle(3, 1);
    cyc(1, 0, 1, 8'h00, 1, 0, "R5");
    cyc(0, 1, 0, 0, 0, 0, "R5");
    cyc(1, 0, 0, 8'h20, 1, 0, "R5");
    idle(3, 1);
    cyc(0, 1, 0, 0, 0, 0, "R5");
    // R4 buffered write
    cyc(1, 0, 1, 8'hAB, 0, 0, "R4");
    cyc(0, 1, 1, 0, 0, 0, "R4");
    cyc(1, 0, 0, 8'hCD, 0, 0, "R4");
    cyc(0, 1, 0, 0, 0, 0, "R4");
    cyc(0, 1, 1, 0, 0, 0, "R4");
    // R3 coherent read across a carry, prescale 1
    cyc(1, 0, 2, 8'hC1, 0, 0, "R3");
    cyc(1, 0, 1, 8'h12, 0, 0, "R3");
    cyc(1, 0, 0, 8'hFE, 0, 0, "R3");
    cyc(0, 1, 0, 0, 1, 0, "R3");
    idle(3, 1);
    cyc(0, 1, 1, 0, 0, 0, "R3");
    check("R3 buffer", {8'h0, bus_rdata}, 16'h0012);
    // R6 wrap with irq enabled
    cyc(1, 0, 1, 8'hFF, 0, 0, "R6");
    cyc(1, 0, 0, 8'hFF, 0, 0, "R6");
    cyc(0, 0, 0, 0, 1, 0, "R6");
    cyc(0, 1, 3, 0, 0, 0, "R6");
    check("R6 irq", {15'h0, irq}, 16'h0001);
    // R11 clear, and set wins over clear
    cyc(1, 0, 3, 8'h01, 0, 0, "R11");
    cyc(0, 1, 3, 0, 0, 0, "R11");
    cyc(1, 0, 3, 8'h00, 0, 0, "R11");
    cyc(0, 1, 3, 0, 0, 0, "R11");
    cyc(1, 0, 1, 8'hFF, 0, 0, "R11");
    cyc(1, 0, 0, 8'hFF, 0, 0, "R11");
    cyc(1, 0, 3, 8'h00, 1, 0, "R11");
    cyc(0, 1, 3, 0, 0, 0, "R11");
    check("R11 set wins", {8'h0, bus_rdata}, 16'h0001);
    // R7 trigger, R8 write beats trigger
    idle(4, 1);
    cyc(0, 0, 0, 0, 1, 1, "R7");
    cyc(0, 1, 0, 0, 0, 0, "R7");
    cyc(1, 0, 0, 8'h55, 1, 1, "R8");
    cyc(0, 1, 0, 0, 0, 0, "R8");
    // R10 live high byte in 8-bit mode
    cyc(1, 0, 2, 8'h01, 0, 0, "R10");
    cyc(1, 0, 1, 8'h3C, 0, 0, "R10");
    cyc(0, 1, 1, 0, 0, 0, "R10");
    check("R10 live", {8'h0, bus_rdata}, 16'h003C);
    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      int unsigned op = $urandom_range(0, 99);
      logic [1:0] a = 2'($urandom_range(0, 3));
      logic [7:0] d = 8'($urandom);
      logic tk = 1'($urandom);
      if (op < 60)      cyc(0, 0, 0, 0, tk, 0, "R2");
      else if (op < 63) cyc(0, 0, 0, 0, tk, 1, "R7");
      else if (op < 75) cyc(1, 0, a, (a == 2) ? ((d & 8'hF0) | 8'h01) : d, tk, 1'($urandom_range(0, 9) == 0), "R8");
      else              cyc(0, 1, a, 0, tk, 0, (a == 1) ? (m_ctl[7] ? "R3" : "R10") : (a == 3 ? "R11" : "R2"));
    end
    // R9 external edges, plain then synchronized
    cyc(1, 0, 2, 8'h03, 0, 0, "R9");
    cyc(1, 0, 0, 8'h00, 0, 0, "R9");
    ext_clk = 1; @(posedge clk); @(negedge clk); peek_lo("R9 plain early", 8'h00);
    @(posedge clk); @(negedge clk); peek_lo("R9 plain", 8'h01);
    ext_clk = 0; repeat (4) @(negedge clk);
    bus_wr = 1; bus_addr = 2; bus_wdata = 8'h07; @(posedge clk); @(negedge clk); bus_wr = 0;
    ext_clk = 1; @(posedge clk); @(negedge clk); peek_lo("R9 sync early", 8'h01);
    @(posedge clk); @(negedge clk); peek_lo("R9 sync mid", 8'h01);
    @(posedge clk); @(negedge clk); peek_lo("R9 sync", 8'h02);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule